// File: doc/BRIEF.md
# Multi-Step Regulator Power-Up Sequencer

This block turns on a bank of regulators in a fixed order after a start-up request. Each rail has three settings. A join bit decides whether the rail takes part at all. A 2-bit step code places it in one of three dependent steps. A 3-bit stagger code delays it within its step. The first step opens a fixed time after the request. Each later step opens a fixed time after every rail enabled so far reports power-good. The rails in a step turn on at their own stagger offsets.

Once the last step is good, a hold timer runs. Power-good is checked when the hold timer starts and again when it ends. Only when both checks pass is the active-low system reset released, together with a one-cycle completion pulse. A downstream power-mode controller uses that pulse to take over the enables.

If a rail stays bad past a recovery window, the attempt fails. All enables drop and the sequence restarts from the first wait. A bounded attempt counter latches a failure flag, and the block then stays off until the request is withdrawn or the block is reset. All timers are parameters in clock ticks.

Top module: `pwrup_sequencer`

## Requirements
- R1: After reset, or while start_req is low, every rail_en is 0. A rail whose rail_seq_en bit is 0 never has its rail_en raised by the sequence.
- R2: Rail i's step is taken from rail_step[2i+1:2i]. Code 00 selects step 1 and code 01 selects step 2. Any code with bit 1 set selects step 3.
- R3: Let the rising edge that first samples start_req high be edge 0. A step-1 rail with stagger code d = rail_dly[3i+2:3i] is enabled on edge T1+1+d·UNIT.
- R4: If start_req is low on the edge where the T1 wait ends, no rail is enabled and the block returns to idle. A later request starts a fresh sequence.
- R5: Consider the edge that first sees every rail enabled in steps 1..k-1 reporting good. A rail in step k (k = 2, 3) with code d is enabled T+d·UNIT+1 edges after that edge, where T is T2 for step 2 and T3 for step 3.
- R6: Rails in the same step are offset from one another by the difference of their stagger codes times UNIT cycles. Code 0 adds no delay.
- R7: A step with no sequenced rails is complete one edge after its own delay, measured from step entry, has run out. The next step then begins.
- R8: sys_rst_n rises T4 edges after the step-3 completion edge, and only if all enabled rails are good at the start and at the end of the T4 hold. A failed check starts a TREC recovery wait, and the hold is retried if the rails recover. seq_done is a single-cycle pulse coincident with the release.
- R9: If any enabled rail is not good TREC cycles after its step's last enable point, the attempt fails. All rail_en drop on that edge and the T1 wait restarts, so a d = 0 step-1 rail is enabled again T1+1 edges later.
- R10: After MAX_TRIES consecutive failed attempts, start_fail is set and all rails stay off while start_req stays high.
- R11: start_fail and the attempt count clear when start_req is low, on reset, and on a successful release.
- R12: start_req going low after the T1 wait drops all rail_en and sys_rst_n on the next edge.
- R13: Directly after reset, sys_rst_n, seq_done and start_fail are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Start-up request, held high while valid |
| rail_seq_en | input | N_RAIL | Per-rail join bit |
| rail_step | input | 2*N_RAIL | Per-rail step code, rail i at bits 2i+1:2i |
| rail_dly | input | 3*N_RAIL | Per-rail stagger code, rail i at bits 3i+2:3i |
| rail_pgood | input | N_RAIL | Per-rail power-good |
| rail_en | output | N_RAIL | Registered per-rail enable |
| sys_rst_n | output | 1 | Active-low reset release, high once the sequence completes |
| seq_done | output | 1 | One-cycle pulse at the release |
| start_fail | output | 1 | Sticky start-up failure flag |

## Verification
The assertions assume that the join bits, step codes and stagger codes are static while a sequence runs. They change only when start_req is low and every enable is off. The bench follows this by loading a new configuration only between sequences. Power-good comes from a model in the bench that follows each enable after a fixed lag, with a fault mask that can pull any rail low. The bench derives exact enable and release cycles from that lag and the timer parameters, including configurations with empty steps and rails that do not take part.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT1,
    ST_STEP,
    ST_HOLD,
    ST_RECOV,
    ST_DONE
  } seq_state_e;

  // step code -> step number 1..3 (bit 0 ignored once bit 1 is set)
  function automatic logic [1:0] step_of(input logic [1:0] code);
    return code[1] ? 2'd3 : (code[0] ? 2'd2 : 2'd1);
  endfunction

endpackage

// File: rtl/pwrup_rail_slot.sv
module pwrup_rail_slot
  import pwrup_seq_pkg::*;
#(
  parameter int CW   = 24,
  parameter int UNIT = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drop,
  input  logic          run,
  input  logic [1:0]    cur_step,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] base,
  input  logic          seq_en,
  input  logic [1:0]    step_code,
  input  logic [2:0]    dly,
  output logic          member,
  output logic          en_q
);

  logic [CW-1:0] fire_at;

  assign member  = seq_en && (step_of(step_code) == cur_step);
  assign fire_at = base + CW'(dly) * CW'(UNIT);

  always_ff @(posedge clk) begin
    if (rst || drop)
      en_q <= 1'b0;
    else if (run && member && (cnt >= fire_at))
      en_q <= 1'b1;
  end

  AST_RAIL_NEEDS_JOIN: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(seq_en)); // R1

  AST_RAIL_RISES_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> $past(run)); // R3

endmodule

// File: rtl/pwrup_retry_track.sv
module pwrup_retry_track #(
  parameter int MAX_TRIES = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bump,
  output logic last_try,
  output logic fail_q
);

  localparam int TW = $clog2(MAX_TRIES + 1);

  logic [TW-1:0] try_q;

  assign last_try = (try_q == TW'(MAX_TRIES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      try_q  <= '0;
      fail_q <= 1'b0;
    end else if (bump) begin
      try_q <= try_q + 1'b1;
      if (last_try)
        fail_q <= 1'b1;
    end
  end

  AST_TRY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    try_q <= TW'(MAX_TRIES)); // R10

  AST_FLAG_FROM_LAST_FAIL: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_q) |-> $past(bump && last_try)); // R10

  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    clear |=> !fail_q); // R11

endmodule

// File: rtl/pwrup_seq_ctrl.sv
module pwrup_seq_ctrl
  import pwrup_seq_pkg::*;
#(
  parameter int N_RAIL = 6,
  parameter int CW     = 24,
  parameter int T1     = 1000,
  parameter int T2     = 1000,
  parameter int T3     = 1000,
  parameter int T4     = 2000,
  parameter int TREC   = 32000,
  parameter int UNIT   = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic [N_RAIL-1:0]   member,
  input  logic [3*N_RAIL-1:0] dly,
  input  logic                pg_ok,
  input  logic                lock,
  input  logic                last_try,
  output logic [1:0]          cur_step,
  output logic                run,
  output logic [CW-1:0]       cnt,
  output logic [CW-1:0]       base,
  output logic                drop,
  output logic                bump,
  output logic                success,
  output logic                nrst_q,
  output logic                done_q
);

  localparam logic [CW-1:0] T1_LAST = CW'(T1 - 1);
  localparam logic [CW-1:0] T4_LAST = CW'(T4 - 1);
  localparam logic [CW-1:0] RC_LAST = CW'(TREC - 1);

  seq_state_e    state, nxt;
  logic [1:0]    nstep;
  logic          restart;
  logic [2:0]    maxd;
  logic [CW-1:0] gate;

  assign run  = (state == ST_STEP);
  assign base = (cur_step == 2'd2) ? CW'(T2) : ((cur_step == 2'd3) ? CW'(T3) : '0);

  // latest stagger among rails of the current step
  always_comb begin
    maxd = '0;
    for (int i = 0; i < N_RAIL; i++)
      if (member[i] && (dly[3*i +: 3] > maxd))
        maxd = dly[3*i +: 3];
  end

  assign gate = base + CW'(maxd) * CW'(UNIT);

  always_comb begin
    nxt     = state;
    nstep   = cur_step;
    restart = 1'b0;
    drop    = 1'b0;
    bump    = 1'b0;
    success = 1'b0;
    case (state)
      ST_IDLE: begin
        drop = 1'b1;
        if (start_req && !lock) begin
          nxt     = ST_WAIT1;
          restart = 1'b1;
        end
      end
      ST_WAIT1: begin
        if (cnt == T1_LAST) begin
          restart = 1'b1;
          if (start_req) begin
            nxt   = ST_STEP;
            nstep = 2'd1;
          end else begin
            nxt = ST_IDLE;
          end
        end
      end
      ST_STEP: begin
        if (!start_req) begin
          nxt = ST_IDLE; drop = 1'b1; restart = 1'b1;
        end else if (cnt > gate) begin
          if (pg_ok) begin
            restart = 1'b1;
            if (cur_step == 2'd3) nxt = ST_HOLD;
            else                  nstep = cur_step + 2'd1;
          end else if (cnt >= gate + CW'(TREC)) begin
            bump = 1'b1; drop = 1'b1; restart = 1'b1;
            nxt  = last_try ? ST_IDLE : ST_WAIT1;
          end
        end
      end
      ST_HOLD: begin
        if (!start_req) begin
          nxt = ST_IDLE; drop = 1'b1; restart = 1'b1;
        end else if (!pg_ok && ((cnt == '0) || (cnt == T4_LAST))) begin
          nxt = ST_RECOV; restart = 1'b1;
        end else if (cnt == T4_LAST) begin
          nxt = ST_DONE; restart = 1'b1; success = 1'b1;
        end
      end
      ST_RECOV: begin
        if (!start_req) begin
          nxt = ST_IDLE; drop = 1'b1; restart = 1'b1;
        end else if (cnt == RC_LAST) begin
          restart = 1'b1;
          if (pg_ok) begin
            nxt = ST_HOLD;
          end else begin
            bump = 1'b1; drop = 1'b1;
            nxt  = last_try ? ST_IDLE : ST_WAIT1;
          end
        end
      end
      ST_DONE: begin
        if (!start_req) begin
          nxt = ST_IDLE; drop = 1'b1; restart = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_step <= '0;
      cnt      <= '0;
      nrst_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state    <= nxt;
      cur_step <= nstep;
      if (restart)
        cnt <= '0;
      else if (state != ST_IDLE && state != ST_DONE)
        cnt <= cnt + 1'b1;
      nrst_q <= (nxt == ST_DONE);
      done_q <= (nxt == ST_DONE) && (state != ST_DONE);
    end
  end

  AST_RELEASE_ALL_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(nrst_q) |-> $past(pg_ok)); // R8

  AST_DONE_WITH_RELEASE: assert property (@(posedge clk) disable iff (rst)
    done_q |-> nrst_q); // R8

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q); // R8

  AST_LOCK_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && lock && start_req) |=> (state == ST_IDLE)); // R10

  AST_RELEASE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(nrst_q) |-> $past(start_req)); // R12

endmodule

// File: rtl/pwrup_sequencer.sv
module pwrup_sequencer #(
  parameter int N_RAIL    = 6,
  parameter int CW        = 24,
  parameter int T1        = 1000,
  parameter int T2        = 1000,
  parameter int T3        = 1000,
  parameter int T4        = 2000,
  parameter int TREC      = 32000,
  parameter int UNIT      = 64,
  parameter int MAX_TRIES = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic [N_RAIL-1:0]   rail_seq_en,
  input  logic [2*N_RAIL-1:0] rail_step,
  input  logic [3*N_RAIL-1:0] rail_dly,
  input  logic [N_RAIL-1:0]   rail_pgood,
  output logic [N_RAIL-1:0]   rail_en,
  output logic                sys_rst_n,
  output logic                seq_done,
  output logic                start_fail
);

  logic [N_RAIL-1:0] member;
  logic [1:0]        cur_step;
  logic              run, drop, bump, success, last_try, pg_ok;
  logic [CW-1:0]     cnt, base;

  // rails not yet enabled do not hold the sequence back
  assign pg_ok = &(rail_pgood | ~rail_en);

  pwrup_seq_ctrl #(
    .N_RAIL(N_RAIL), .CW(CW), .T1(T1), .T2(T2), .T3(T3), .T4(T4),
    .TREC(TREC), .UNIT(UNIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start_req(start_req),
    .member(member), .dly(rail_dly), .pg_ok(pg_ok),
    .lock(start_fail), .last_try(last_try),
    .cur_step(cur_step), .run(run), .cnt(cnt), .base(base),
    .drop(drop), .bump(bump), .success(success),
    .nrst_q(sys_rst_n), .done_q(seq_done)
  );

  pwrup_retry_track #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk(clk), .rst(rst), .clear(!start_req || success), .bump(bump),
    .last_try(last_try), .fail_q(start_fail)
  );

  for (genvar g = 0; g < N_RAIL; g++) begin : g_rail
    pwrup_rail_slot #(.CW(CW), .UNIT(UNIT)) u_slot (
      .clk(clk), .rst(rst), .drop(drop), .run(run),
      .cur_step(cur_step), .cnt(cnt), .base(base),
      .seq_en(rail_seq_en[g]), .step_code(rail_step[2*g +: 2]),
      .dly(rail_dly[3*g +: 3]),
      .member(member[g]), .en_q(rail_en[g])
    );
  end

endmodule

// File: tb/pwrup_sequencer_bench.sv
`timescale 1ns/1ps
module pwrup_sequencer_bench;
  localparam int N = 4, T1 = 20, T2 = 10, T3 = 12, T4 = 16, TREC = 40;
  localparam int U = 4, MAXT = 5, PGL = 3;

  // {seq_en[3:0], step codes (rail i at 2i), stagger codes (rail i at 3i)}
  localparam logic [23:0] VEC [5] = '{
    {4'b1111, 8'b11_10_01_00, 12'b011_001_010_000},
    {4'b1011, 8'b01_00_00_00, 12'b101_100_000_011},
    {4'b1110, 8'b10_11_10_00, 12'b111_000_010_001},
    {4'b0101, 8'b00_01_00_01, 12'b000_110_000_010},
    {4'b1111, 8'b00_00_00_00, 12'b001_111_000_000}
  };

  logic clk = 0, rst = 1, start_req = 0;
  logic [N-1:0] seq_en = '0, bad = '0, rail_pgood, rail_en;
  logic [2*N-1:0] step = '0;
  logic [3*N-1:0] dly = '0;
  logic sys_rst_n, seq_done, start_fail;
  logic [PGL-1:0] pg_sr [N];

  int cyc = 0, n_chk = 0, n_err = 0;
  int first_en [N], rises [N], rise0_t [8], exp_en [N];
  int first_rel = -1, done_cnt = 0, exp_rel = 0, c0 = 0;
  logic [N-1:0] prev_en = '0;

  always #2 clk = ~clk;

  pwrup_sequencer #(.N_RAIL(N), .CW(16), .T1(T1), .T2(T2), .T3(T3), .T4(T4),
    .TREC(TREC), .UNIT(U), .MAX_TRIES(MAXT)) u_pwrup_sequencer (
    .clk(clk), .rst(rst), .start_req(start_req), .rail_seq_en(seq_en),
    .rail_step(step), .rail_dly(dly), .rail_pgood(rail_pgood),
    .rail_en(rail_en), .sys_rst_n(sys_rst_n), .seq_done(seq_done),
    .start_fail(start_fail));

  always @(posedge clk) cyc <= cyc + 1;

  // power-good model: fixed lag behind the enable, forced low by bad
  for (genvar g = 0; g < N; g++) begin : g_pg
    always @(negedge clk) pg_sr[g] <= {pg_sr[g][PGL-2:0], rail_en[g]};
    assign rail_pgood[g] = pg_sr[g][PGL-1] & ~bad[g];
  end

  always @(negedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (rail_en[i] && !prev_en[i]) begin
        if (i == 0 && rises[0] < 8) rise0_t[rises[0]] = cyc;
        rises[i]++;
      end
      if (rail_en[i] && first_en[i] < 0) first_en[i] = cyc;
    end
    prev_en = rail_en;
    if (sys_rst_n && first_rel < 0) first_rel = cyc;
    if (seq_done) done_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic clear_rec();
    for (int i = 0; i < N; i++) begin first_en[i] = -1; rises[i] = 0; end
    first_rel = -1; done_cnt = 0;
  endtask

  task automatic apply(input logic [23:0] v);
    seq_en = v[23:20]; step = v[19:12]; dly = v[11:0];
  endtask

  // expected enable / release cycles from the timing requirements
  task automatic calc(input int c);
    int e, tp, base, maxd, d, t, s_of;
    e = c + 1 + T1; tp = -1;
    for (int i = 0; i < N; i++) exp_en[i] = -1;
    for (int s = 1; s <= 3; s++) begin
      base = (s == 1) ? 0 : ((s == 2) ? T2 : T3);
      maxd = 0;
      for (int i = 0; i < N; i++) begin
        s_of = step[2*i+1] ? 3 : (step[2*i] ? 2 : 1);
        if (seq_en[i] && s_of == s) begin
          d = int'(dly[3*i +: 3]);
          t = e + 1 + base + d * U;
          exp_en[i] = t;
          if (t + PGL - 1 > tp) tp = t + PGL - 1;
          if (d > maxd) maxd = d;
        end
      end
      e = (tp + 1 > e + base + maxd * U + 2) ? tp + 1 : e + base + maxd * U + 2;
    end
    exp_rel = e + T4;
  endtask

  task automatic begin_seq(input logic [23:0] v);
    @(negedge clk); apply(v);
    repeat (PGL + 2) @(negedge clk);
    clear_rec(); c0 = cyc; start_req = 1; calc(c0);
  endtask

  task automatic end_seq();
    start_req = 0;
    @(negedge clk);
    chk(rail_en == 0 && !sys_rst_n, "R12 off after request drop", int'(rail_en), 0);
    repeat (PGL + 2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) pg_sr[i] = '0;
    clear_rec();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(rail_en == 0, "R1 R13 reset rail_en", int'(rail_en), 0);
    chk(!sys_rst_n && !seq_done && !start_fail, "R13 reset flags",
        int'({sys_rst_n, seq_done, start_fail}), 0);

    // R4: request gone when the T1 wait ends
    @(negedge clk); apply(VEC[0]); clear_rec();
    start_req = 1; @(negedge clk); start_req = 0;
    repeat (T1 + 40) @(negedge clk);
    chk(rises[0] + rises[1] + rises[2] + rises[3] == 0, "R4 abort no enable",
        rises[0] + rises[1] + rises[2] + rises[3], 0);
    chk(!sys_rst_n, "R4 abort no release", int'(sys_rst_n), 0);

    // table walk: exact enable and release cycles
    for (int v = 0; v < 5; v++) begin
      begin_seq(VEC[v]);
      for (int k = 0; k < 1500 && first_rel < 0; k++) @(negedge clk);
      repeat (3) @(negedge clk);
      for (int i = 0; i < N; i++) begin
        if (!seq_en[i])
          chk(first_en[i] < 0, "R1 unsequenced rail stays off", first_en[i], -1);
        else if (step[2*i +: 2] == 2'b00)
          chk(first_en[i] == exp_en[i], "R3 R6 step-1 enable cycle", first_en[i], exp_en[i]);
        else
          chk(first_en[i] == exp_en[i], "R2 R5 R6 R7 later-step enable cycle",
              first_en[i], exp_en[i]);
      end
      chk(first_rel == exp_rel, "R8 release cycle", first_rel, exp_rel);
      chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
      chk(rail_en == seq_en, "R1 final enables", int'(rail_en), int'(seq_en));
      end_seq();
    end

    // R8: rail bad across the end-of-hold check, then recovers
    begin_seq(VEC[0]);
    for (int k = 0; k < 1500 && !(&(rail_pgood | ~seq_en)); k++) @(negedge clk);
    repeat (2) @(negedge clk);
    bad[1] = 1;
    repeat (T4 + 10) @(negedge clk);
    chk(!sys_rst_n, "R8 held while rail bad", int'(sys_rst_n), 0);
    bad[1] = 0; c0 = cyc;
    for (int k = 0; k < 600 && first_rel < 0; k++) @(negedge clk);
    chk(sys_rst_n && first_rel > c0, "R8 release after recovery", first_rel, c0 + 1);
    chk(rises[0] == 1, "R8 no retry during recovery", rises[0], 1);
    end_seq();

    // R9 R10: permanent fault on a step-1 rail
    bad[0] = 1;
    begin_seq(VEC[0]);
    for (int k = 0; k < 4000 && !start_fail; k++) @(negedge clk);
    chk(start_fail, "R10 fail flag set", int'(start_fail), 1);
    chk(rises[0] == MAXT, "R10 attempt count", rises[0], MAXT);
    chk(rise0_t[1] - rise0_t[0] == TREC + T1 + 1, "R9 retry restarts from t1",
        rise0_t[1] - rise0_t[0], TREC + T1 + 1);
    chk(rises[1] == 0, "R5 step 2 never opens", rises[1], 0);
    repeat (300) @(negedge clk);
    chk(rail_en == 0 && rises[0] == MAXT, "R10 stays off while locked", rises[0], MAXT);
    start_req = 0;
    @(negedge clk);
    chk(!start_fail, "R11 request low clears flag", int'(start_fail), 0);
    repeat (PGL + 2) @(negedge clk);

    // R11: reset clears the flag
    begin_seq(VEC[0]);
    for (int k = 0; k < 4000 && !start_fail; k++) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0; start_req = 0;
    @(negedge clk);
    chk(!start_fail && rail_en == 0, "R11 reset clears flag", int'(start_fail), 0);
    bad = '0;
    repeat (PGL + 2) @(negedge clk);

    // retry after clear succeeds
    begin_seq(VEC[4]);
    for (int k = 0; k < 1500 && first_rel < 0; k++) @(negedge clk);
    chk(first_rel == exp_rel, "R11 restart after clear", first_rel, exp_rel);
    end_seq();

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule